// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block keeps the current privilege level of a single-hart core (Machine, Supervisor or User) and owns the registers that describe a trap at each of the two handling levels: status, cause, saved PC and handler base. Each cycle the pipeline can present one instruction outcome. That outcome is an environment call, an illegal instruction, a generic exception carrying its own cause code, a return from Machine or Supervisor level, or a control-register access. The block decides what happens, updates its state on the next clock edge and, one cycle later, drives a one-cycle redirect strobe with the fetch address the core must jump to.

Every exception raised below Machine level is sent to the Supervisor handler when its bit in a per-cause delegation register is set. Otherwise it goes to the Machine handler. A trap never lowers the privilege level. Control-register accesses are checked against the privilege level encoded in the register address. An access that is not permitted becomes an illegal-instruction trap and has no effect.

Top module: `hart_priv_trap`

## Requirements
- R1: While reset is held and in the first cycle after it, the mode is Machine (`curMode` = 2'b11) and `redirectValid` is low. All status, delegation, cause, saved-PC and handler-base registers read as zero.
- R2: Mode encoding is 00 = User, 01 = Supervisor, 11 = Machine. Trap cause codes are 8 for an environment call from User, 9 from Supervisor and 11 from Machine, and 2 for an illegal instruction. A generic exception records `excCause` unchanged.
- R3: On a trap, the saved-PC register of the target level takes `instrPc` of the trapping instruction itself, and its cause register takes the cause. In the next cycle `redirectValid` is high for exactly one cycle, with `redirectPc` equal to that level's handler base as it stood before the trap.
- R4: A trap taken in User or Supervisor mode enters Supervisor mode when bit [cause] of the delegation register is 1, and enters Machine mode otherwise. A trap never leaves the hart in User mode.
- R5: A trap taken in Machine mode always stays in Machine mode, whatever the delegation register holds.
- R6: On a trap into Machine mode, machine status bit 7 takes the old bit 3, bit 3 is cleared, and bits 12:11 take the mode the trap was taken from.
- R7: On a trap into Supervisor mode, status bit 8 becomes 1 if the trap was taken in Supervisor mode and 0 if it was taken in User mode.
- R8: A return from Machine level, issued in Machine mode, sets the mode to machine status bits 12:11, restores bit 3 from bit 7, sets bit 7 to 1, sets bits 12:11 to User and redirects to the machine saved PC.
- R9: A return from Supervisor level, issued in Supervisor or Machine mode, enters Supervisor mode if status bit 8 is 1 and User mode if it is 0. It then clears bit 8 and redirects to the supervisor saved PC.
- R10: A Machine-level return outside Machine mode, or a Supervisor-level return in User mode, is taken as an illegal-instruction trap (cause 2).
- R11: A control-register access needs a mode numerically at least `csrAddr[9:8]`. A permitted access raises `csrAck` in the same cycle, shows the register on `csrRdata` and writes at the next edge when `csrWrite` is set. A refused access leaves `csrAck` low and `csrRdata` zero, writes nothing and becomes a cause-2 trap.
- R12: When several requests arrive in one cycle, only one acts, in this order: illegal instruction, environment call, generic exception, Machine-level return, Supervisor-level return, register access.
- R13: A write of 2'b10 to machine status bits 12:11 leaves that field unchanged. Writes to handler-base and saved-PC registers clear bits 1:0.
- R14: Register map: 0x300 machine status (bits 3, 7, 8, 12:11), 0x302 delegation, 0x305/0x341/0x342 machine handler base, saved PC and cause; 0x100 supervisor status (bit 8 only), 0x105/0x141/0x142 supervisor handler base, saved PC and cause. Unmapped permitted addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrPc | input | XLEN | Address of the instruction presenting the request |
| ecallReq | input | 1 | Environment call |
| illegalReq | input | 1 | Illegal instruction found by decode |
| excReq | input | 1 | Generic exception |
| excCause | input | CAUSE_W | Cause code of the generic exception |
| mretReq | input | 1 | Return from Machine level |
| sretReq | input | 1 | Return from Supervisor level |
| csrReq | input | 1 | Control-register access |
| csrWrite | input | 1 | The access writes `csrWdata` |
| csrAddr | input | 12 | Control-register address |
| csrWdata | input | XLEN | Write data |
| curMode | output | 2 | Current privilege mode |
| csrAck | output | 1 | Access permitted and performed |
| csrRdata | output | XLEN | Read data of a permitted access |
| redirectValid | output | 1 | One-cycle fetch redirect strobe |
| redirectPc | output | XLEN | Redirect target, valid with the strobe |

## Verification
On every cycle the assertions check the following. The mode never takes the unused encoding. A trap from Machine mode stays in Machine mode, and one from User mode never stays in User mode. Each trap or return is followed by exactly one redirect strobe and no strobe appears without a cause. A granted register access always meets its address privilege. The bench's scenarios are needed for the rest. They cover the cause codes per mode, the saved PC being the trapping address, the status bit shuffles on trap and return, delegation per cause, the refused accesses leaving registers intact, and the order among simultaneous requests. A cycle-accurate reference model checks all of these by comparing the outputs every cycle and reading the registers back through the access port.

// File: rtl/hart_priv_pkg.sv
package hart_priv_pkg;

  typedef enum logic [1:0] {
    MODE_U = 2'b00,
    MODE_S = 2'b01,
    MODE_M = 2'b11
  } mode_e;

  // Strobes from control to datapath; at most one action bit is set.
  typedef struct packed {
    logic takeTrap;
    logic toSuper;
    logic doMret;
    logic doSret;
    logic csrWr;
  } ctrl_t;

  localparam int NUM_LVL = 2;
  localparam int LVL_S   = 0;
  localparam int LVL_M   = 1;

  // Address bits 9:8 carry the minimum privilege of a register.
  localparam logic [11:0] CSR_S_BASE  = 12'h100;
  localparam logic [11:0] CSR_M_BASE  = 12'h300;
  localparam logic [11:0] OFS_TVEC    = 12'h005;
  localparam logic [11:0] OFS_EPC     = 12'h041;
  localparam logic [11:0] OFS_CAUSE   = 12'h042;
  localparam logic [11:0] CSR_SSTATUS = 12'h100;
  localparam logic [11:0] CSR_MSTATUS = 12'h300;
  localparam logic [11:0] CSR_DELEG   = 12'h302;

  localparam int ST_MIE  = 3;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  localparam int CODE_ILLEGAL = 2;
  localparam int CODE_ECALL_U = 8;
  localparam int CODE_ECALL_S = 9;
  localparam int CODE_ECALL_M = 11;

endpackage

// File: rtl/hart_priv_ctrl.sv
module hart_priv_ctrl
  import hart_priv_pkg::*;
#(
  parameter int CAUSE_W = 5,
  localparam int DELEG_W = 1 << CAUSE_W
) (
  input  mode_e              curMode,
  input  logic [DELEG_W-1:0] delegVec,
  input  logic               ecallReq,
  input  logic               illegalReq,
  input  logic               excReq,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic               mretReq,
  input  logic               sretReq,
  input  logic               csrReq,
  input  logic               csrWrite,
  input  logic [11:0]        csrAddr,
  output ctrl_t              strb,
  output logic [CAUSE_W-1:0] trapCause,
  output logic               csrAck
);

  logic               privOk;
  logic               raise;
  logic [CAUSE_W-1:0] causeSel;
  logic [CAUSE_W-1:0] ecallCode;

  assign privOk = (csrAddr[9:8] <= 2'(curMode));

  always_comb begin
    unique case (curMode)
      MODE_U:  ecallCode = CAUSE_W'(CODE_ECALL_U);
      MODE_S:  ecallCode = CAUSE_W'(CODE_ECALL_S);
      default: ecallCode = CAUSE_W'(CODE_ECALL_M);
    endcase
  end

  // Fixed priority: illegal, ecall, exception, mret, sret, register access.
  always_comb begin
    raise    = 1'b0;
    causeSel = '0;
    csrAck   = 1'b0;
    strb     = '0;
    if (illegalReq) begin
      raise    = 1'b1;
      causeSel = CAUSE_W'(CODE_ILLEGAL);
    end else if (ecallReq) begin
      raise    = 1'b1;
      causeSel = ecallCode;
    end else if (excReq) begin
      raise    = 1'b1;
      causeSel = excCause;
    end else if (mretReq) begin
      if (curMode == MODE_M) strb.doMret = 1'b1;
      else begin
        raise    = 1'b1;
        causeSel = CAUSE_W'(CODE_ILLEGAL);
      end
    end else if (sretReq) begin
      if (curMode != MODE_U) strb.doSret = 1'b1;
      else begin
        raise    = 1'b1;
        causeSel = CAUSE_W'(CODE_ILLEGAL);
      end
    end else if (csrReq) begin
      if (privOk) begin
        csrAck     = 1'b1;
        strb.csrWr = csrWrite;
      end else begin
        raise    = 1'b1;
        causeSel = CAUSE_W'(CODE_ILLEGAL);
      end
    end
    strb.takeTrap = raise;
    strb.toSuper  = raise && (curMode != MODE_M) && delegVec[causeSel];
  end

  assign trapCause = causeSel;

endmodule

// File: rtl/hart_priv_dp.sv
module hart_priv_dp
  import hart_priv_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5,
  localparam int DELEG_W = 1 << CAUSE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              strb,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    instrPc,
  input  logic [11:0]        csrAddr,
  input  logic [XLEN-1:0]    csrWdata,
  output mode_e              curMode,
  output logic [DELEG_W-1:0] delegVec,
  output logic [XLEN-1:0]    rdRaw,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc
);

  mode_e              modeQ;
  logic               mieQ, mpieQ, sppQ;
  logic [1:0]         mppQ;
  logic [DELEG_W-1:0] delegQ;

  logic [XLEN-1:0] tvecArr [NUM_LVL];
  logic [XLEN-1:0] epcArr  [NUM_LVL];
  logic [XLEN-1:0] rdLvl   [NUM_LVL];

  logic wrMStatus, wrSStatus, wrDeleg;
  assign wrMStatus = strb.csrWr && (csrAddr == CSR_MSTATUS);
  assign wrSStatus = strb.csrWr && (csrAddr == CSR_SSTATUS);
  assign wrDeleg   = strb.csrWr && (csrAddr == CSR_DELEG);

  // Per-level trap record: handler base, saved PC, cause.
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    localparam logic [11:0] BASE   = (g == LVL_M) ? CSR_M_BASE : CSR_S_BASE;
    localparam logic        IS_SUP = (g == LVL_S);

    logic [XLEN-1:0]    tvecQ, epcQ;
    logic [CAUSE_W-1:0] causeQ;
    logic               trapHere;

    assign trapHere = strb.takeTrap && (strb.toSuper == IS_SUP);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tvecQ  <= '0;
        epcQ   <= '0;
        causeQ <= '0;
      end else begin
        if (trapHere) begin
          epcQ   <= instrPc;
          causeQ <= trapCause;
        end else if (strb.csrWr) begin
          if (csrAddr == BASE + OFS_EPC)   epcQ   <= {csrWdata[XLEN-1:2], 2'b00};
          if (csrAddr == BASE + OFS_CAUSE) causeQ <= csrWdata[CAUSE_W-1:0];
        end
        if (strb.csrWr && (csrAddr == BASE + OFS_TVEC))
          tvecQ <= {csrWdata[XLEN-1:2], 2'b00};
      end
    end

    assign tvecArr[g] = tvecQ;
    assign epcArr[g]  = epcQ;

    always_comb begin
      if (csrAddr == BASE + OFS_TVEC)       rdLvl[g] = tvecQ;
      else if (csrAddr == BASE + OFS_EPC)   rdLvl[g] = epcQ;
      else if (csrAddr == BASE + OFS_CAUSE) rdLvl[g] = {{(XLEN-CAUSE_W){1'b0}}, causeQ};
      else                                  rdLvl[g] = '0;
    end
  end

  // Mode and status fields.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_M;
      mieQ  <= 1'b0;
      mpieQ <= 1'b0;
      mppQ  <= 2'(MODE_U);
      sppQ  <= 1'b0;
    end else if (strb.takeTrap) begin
      if (strb.toSuper) begin
        sppQ  <= (modeQ == MODE_S);
        modeQ <= MODE_S;
      end else begin
        mpieQ <= mieQ;
        mieQ  <= 1'b0;
        mppQ  <= 2'(modeQ);
        modeQ <= MODE_M;
      end
    end else if (strb.doMret) begin
      modeQ <= mode_e'(mppQ);
      mieQ  <= mpieQ;
      mpieQ <= 1'b1;
      mppQ  <= 2'(MODE_U);
    end else if (strb.doSret) begin
      modeQ <= sppQ ? MODE_S : MODE_U;
      sppQ  <= 1'b0;
    end else if (wrMStatus) begin
      mieQ  <= csrWdata[ST_MIE];
      mpieQ <= csrWdata[ST_MPIE];
      sppQ  <= csrWdata[ST_SPP];
      if (csrWdata[ST_MPP+1:ST_MPP] != 2'b10) mppQ <= csrWdata[ST_MPP+1:ST_MPP];
    end else if (wrSStatus) begin
      sppQ <= csrWdata[ST_SPP];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) delegQ <= '0;
    else if (wrDeleg) delegQ <= csrWdata[DELEG_W-1:0];
  end

  // Redirect is registered: visible the cycle after the deciding edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectValid <= 1'b0;
      redirectPc    <= '0;
    end else begin
      redirectValid <= strb.takeTrap || strb.doMret || strb.doSret;
      if (strb.takeTrap)
        redirectPc <= strb.toSuper ? tvecArr[LVL_S] : tvecArr[LVL_M];
      else if (strb.doMret)
        redirectPc <= epcArr[LVL_M];
      else if (strb.doSret)
        redirectPc <= epcArr[LVL_S];
    end
  end

  logic [XLEN-1:0] statusWord;
  always_comb begin
    statusWord                   = '0;
    statusWord[ST_MIE]           = mieQ;
    statusWord[ST_MPIE]          = mpieQ;
    statusWord[ST_SPP]           = sppQ;
    statusWord[ST_MPP+1:ST_MPP]  = mppQ;
  end

  always_comb begin
    rdRaw = rdLvl[LVL_S] | rdLvl[LVL_M];
    unique case (csrAddr)
      CSR_MSTATUS: rdRaw = statusWord;
      CSR_SSTATUS: begin
        rdRaw         = '0;
        rdRaw[ST_SPP] = sppQ;
      end
      CSR_DELEG:   rdRaw = {{(XLEN-DELEG_W){1'b0}}, delegQ};
      default: ;
    endcase
  end

  assign curMode  = modeQ;
  assign delegVec = delegQ;

endmodule

// File: rtl/hart_priv_trap.sv
module hart_priv_trap
  import hart_priv_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [XLEN-1:0]    instrPc,
  input  logic               ecallReq,
  input  logic               illegalReq,
  input  logic               excReq,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic               mretReq,
  input  logic               sretReq,
  input  logic               csrReq,
  input  logic               csrWrite,
  input  logic [11:0]        csrAddr,
  input  logic [XLEN-1:0]    csrWdata,
  output logic [1:0]         curMode,
  output logic               csrAck,
  output logic [XLEN-1:0]    csrRdata,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc
);

  localparam int DELEG_W = 1 << CAUSE_W;

  ctrl_t              strb;
  mode_e              modeNow;
  logic [DELEG_W-1:0] delegVec;
  logic [CAUSE_W-1:0] trapCause;
  logic [XLEN-1:0]    rdRaw;

  hart_priv_ctrl #(.CAUSE_W(CAUSE_W)) u_ctrl (
    .curMode   (modeNow),
    .delegVec  (delegVec),
    .ecallReq  (ecallReq),
    .illegalReq(illegalReq),
    .excReq    (excReq),
    .excCause  (excCause),
    .mretReq   (mretReq),
    .sretReq   (sretReq),
    .csrReq    (csrReq),
    .csrWrite  (csrWrite),
    .csrAddr   (csrAddr),
    .strb      (strb),
    .trapCause (trapCause),
    .csrAck    (csrAck)
  );

  hart_priv_dp #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .trapCause    (trapCause),
    .instrPc      (instrPc),
    .csrAddr      (csrAddr),
    .csrWdata     (csrWdata),
    .curMode      (modeNow),
    .delegVec     (delegVec),
    .rdRaw        (rdRaw),
    .redirectValid(redirectValid),
    .redirectPc   (redirectPc)
  );

  assign curMode  = 2'(modeNow);
  assign csrRdata = csrAck ? rdRaw : '0;

endmodule

// File: rtl/hart_priv_trap_chk.sv
module hart_priv_trap_chk #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [XLEN-1:0]    instrPc,
  input logic               ecallReq,
  input logic               illegalReq,
  input logic               excReq,
  input logic [CAUSE_W-1:0] excCause,
  input logic               mretReq,
  input logic               sretReq,
  input logic               csrReq,
  input logic               csrWrite,
  input logic [11:0]        csrAddr,
  input logic [XLEN-1:0]    csrWdata,
  input logic [1:0]         curMode,
  input logic               csrAck,
  input logic [XLEN-1:0]    csrRdata,
  input logic               redirectValid,
  input logic [XLEN-1:0]    redirectPc
);

  logic excLike, flowEvent;
  assign excLike   = illegalReq || ecallReq || excReq;
  assign flowEvent = excLike || mretReq || sretReq || (csrReq && !csrAck);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (curMode == 2'b11 && !redirectValid));

  // R13
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    curMode != 2'b10);

  // R5
  machine_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excLike && curMode == 2'b11) |=> curMode == 2'b11);

  // R4
  user_leaves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excLike && curMode == 2'b00) |=> curMode != 2'b00);

  // R3
  redirect_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    flowEvent |=> redirectValid);

  // R3
  redirect_caused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flowEvent && rstN) |=> !redirectValid);

  // R11
  grant_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrAck |-> (csrAddr[9:8] <= curMode));

  // R11
  refused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csrAck |-> csrRdata == '0);

endmodule

bind hart_priv_trap hart_priv_trap_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (.*);

// File: tb/tb_hart_priv_trap.sv
`timescale 1ns/1ps
module tb_hart_priv_trap;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] instrPc;
  logic        ecallReq, illegalReq, excReq, mretReq, sretReq;
  logic [4:0]  excCause;
  logic        csrReq, csrWrite;
  logic [11:0] csrAddr;
  logic [31:0] csrWdata;
  logic [1:0]  curMode;
  logic        csrAck;
  logic [31:0] csrRdata;
  logic        redirectValid;
  logic [31:0] redirectPc;

  always #4 clk = ~clk;

  hart_priv_trap dut (.*);

  int    errors = 0;
  int    checks = 0;
  string curTag = "R1";
  bit    finished = 0;

  // Reference model state
  bit [1:0]  mMode;
  bit        mMie, mMpie, mSpp;
  bit [1:0]  mMpp;
  bit [31:0] mDeleg;
  bit [31:0] mTv [2];
  bit [31:0] mEp [2];
  bit [4:0]  mCa [2];
  bit        mRv;
  bit [31:0] mRpc;

  task automatic modelReset();
    mMode = 2'b11; mMie = 0; mMpie = 0; mSpp = 0; mMpp = 0; mDeleg = 0;
    for (int i = 0; i < 2; i++) begin mTv[i] = 0; mEp[i] = 0; mCa[i] = 0; end
    mRv = 0; mRpc = 0;
  endtask

  function automatic bit [31:0] mRead(bit [11:0] a);
    case (a)
      12'h300: return (32'(mMpp) << 11) | (32'(mSpp) << 8) | (32'(mMpie) << 7) | (32'(mMie) << 3);
      12'h100: return 32'(mSpp) << 8;
      12'h302: return mDeleg;
      12'h305: return mTv[1];
      12'h341: return mEp[1];
      12'h342: return 32'(mCa[1]);
      12'h105: return mTv[0];
      12'h141: return mEp[0];
      12'h142: return 32'(mCa[0]);
      default: return 0;
    endcase
  endfunction

  // kind: 0 none, 1 trap, 2 mret, 3 sret, 4 granted access
  task automatic mDecide(output int kind, output bit [4:0] cz);
    kind = 0; cz = 0;
    if (illegalReq) begin kind = 1; cz = 2; end
    else if (ecallReq) begin kind = 1; cz = (mMode == 0) ? 5'd8 : (mMode == 1) ? 5'd9 : 5'd11; end
    else if (excReq) begin kind = 1; cz = excCause; end
    else if (mretReq) begin if (mMode == 3) kind = 2; else begin kind = 1; cz = 2; end end
    else if (sretReq) begin if (mMode != 0) kind = 3; else begin kind = 1; cz = 2; end end
    else if (csrReq) begin
      if (int'(csrAddr[9:8]) <= int'(mMode)) kind = 4; else begin kind = 1; cz = 2; end
    end
  endtask

  task automatic modelStep();
    int kind; bit [4:0] cz;
    mDecide(kind, cz);
    mRv = 0;
    if (kind == 1) begin
      mRv = 1;
      if (mMode != 3 && mDeleg[cz]) begin
        mEp[0] = instrPc; mCa[0] = cz; mSpp = (mMode == 1); mMode = 1; mRpc = mTv[0];
      end else begin
        mEp[1] = instrPc; mCa[1] = cz; mMpie = mMie; mMie = 0; mMpp = mMode; mMode = 3; mRpc = mTv[1];
      end
    end else if (kind == 2) begin
      mRv = 1; mRpc = mEp[1]; mMode = mMpp; mMie = mMpie; mMpie = 1; mMpp = 0;
    end else if (kind == 3) begin
      mRv = 1; mRpc = mEp[0]; mMode = mSpp ? 2'd1 : 2'd0; mSpp = 0;
    end else if (kind == 4 && csrWrite) begin
      case (csrAddr)
        12'h300: begin
          mMie = csrWdata[3]; mMpie = csrWdata[7]; mSpp = csrWdata[8];
          if (csrWdata[12:11] != 2'b10) mMpp = csrWdata[12:11];
        end
        12'h100: mSpp = csrWdata[8];
        12'h302: mDeleg = csrWdata;
        12'h305: mTv[1] = {csrWdata[31:2], 2'b00};
        12'h341: mEp[1] = {csrWdata[31:2], 2'b00};
        12'h342: mCa[1] = csrWdata[4:0];
        12'h105: mTv[0] = {csrWdata[31:2], 2'b00};
        12'h141: mEp[0] = {csrWdata[31:2], 2'b00};
        12'h142: mCa[0] = csrWdata[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int kind; bit [4:0] cz;
    mDecide(kind, cz);
    check({curTag, " mode"}, 32'(curMode), 32'(mMode));
    check({curTag, " redirect strobe"}, 32'(redirectValid), 32'(mRv));
    if (mRv) check({curTag, " redirect pc"}, redirectPc, mRpc);
    check({curTag, " ack"}, 32'(csrAck), 32'(kind == 4));
    check({curTag, " rdata"}, csrRdata, (kind == 4) ? mRead(csrAddr) : 32'h0);
  endtask

  task automatic clearIn();
    ecallReq = 0; illegalReq = 0; excReq = 0; excCause = 0; mretReq = 0; sretReq = 0;
    csrReq = 0; csrWrite = 0; csrAddr = 0; csrWdata = 0;
  endtask

  task automatic cyc();
    #1 compareAll();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    clearIn();
  endtask

  task automatic csrW(bit [11:0] a, bit [31:0] v);
    csrReq = 1; csrWrite = 1; csrAddr = a; csrWdata = v; cyc();
  endtask

  task automatic csrR(string tag, bit [11:0] a, bit [31:0] exp);
    csrReq = 1; csrAddr = a;
    #1 check(tag, 32'(csrAck), 32'd1);
    check(tag, csrRdata, exp);
    cyc();
  endtask

  task automatic issue(bit ec, bit il, bit ex, bit mr, bit sr, bit [4:0] cz, bit [31:0] pc);
    ecallReq = ec; illegalReq = il; excReq = ex; mretReq = mr; sretReq = sr;
    excCause = cz; instrPc = pc; cyc();
  endtask

  task automatic expRedir(string tag, bit [1:0] mode, bit [31:0] pc);
    check(tag, 32'(curMode), 32'(mode));
    check(tag, 32'(redirectValid), 32'd1);
    check(tag, redirectPc, pc);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clearIn(); instrPc = 0; rstN = 0; modelReset();
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1 reset mode", 32'(curMode), 32'h3);
    check("R1 reset strobe", 32'(redirectValid), 32'h0);
    rstN = 1;
    curTag = "R1";
    csrR("R1 status zero", 12'h300, 32'h0);
    csrR("R1 cause zero", 12'h342, 32'h0);
    csrR("R1 epc zero", 12'h341, 32'h0);

    curTag = "R14";
    csrW(12'h305, 32'h103); csrR("R13 tvec align", 12'h305, 32'h100);
    csrW(12'h105, 32'h202); csrR("R14 stvec", 12'h105, 32'h200);
    csrW(12'h302, 32'h120); csrR("R14 deleg", 12'h302, 32'h120);

    curTag = "R13";
    csrW(12'h300, 32'h1000); csrR("R13 mpp 10 ignored", 12'h300, 32'h0);
    csrW(12'h300, 32'h80);   csrR("R13 status", 12'h300, 32'h80);
    csrW(12'h341, 32'h1001); csrR("R13 epc align", 12'h341, 32'h1000);

    curTag = "R8";
    issue(0, 0, 0, 1, 0, 0, 32'h50);
    expRedir("R8 mret to user", 2'b00, 32'h1000);

    curTag = "R4";
    issue(1, 0, 0, 0, 0, 0, 32'h1004);
    expRedir("R4 delegated user ecall", 2'b01, 32'h200);
    csrR("R2 cause 8", 12'h142, 32'd8);
    csrR("R3 epc is trapping pc", 12'h141, 32'h1004);
    csrR("R7 spp from user", 12'h100, 32'h0);

    curTag = "R11";
    csrReq = 1; csrWrite = 1; csrAddr = 12'h305; csrWdata = 32'hfff0; instrPc = 32'h2000;
    #1 check("R11 refused ack", 32'(csrAck), 32'd0);
    cyc();
    expRedir("R11 refused traps to machine", 2'b11, 32'h100);
    csrR("R11 write had no effect", 12'h305, 32'h100);
    csrR("R11 cause 2", 12'h342, 32'd2);
    csrR("R6 status after trap", 12'h300, 32'h880);

    curTag = "R8";
    issue(0, 0, 0, 1, 0, 0, 32'h10);
    expRedir("R8 mret to supervisor", 2'b01, 32'h2000);
    curTag = "R2";
    issue(1, 0, 0, 0, 0, 0, 32'h3000);
    expRedir("R2 supervisor ecall to machine", 2'b11, 32'h100);
    csrR("R2 cause 9", 12'h342, 32'd9);
    csrR("R6 status", 12'h300, 32'h880);

    curTag = "R9";
    csrW(12'h100, 32'h100); csrW(12'h141, 32'h4000);
    issue(0, 0, 0, 0, 1, 0, 32'h20);
    expRedir("R9 sret from machine", 2'b01, 32'h4000);
    csrR("R9 spp cleared", 12'h100, 32'h0);
    issue(0, 0, 0, 0, 1, 0, 32'h30);
    expRedir("R9 sret to user", 2'b00, 32'h4000);

    curTag = "R10";
    issue(0, 0, 0, 1, 0, 0, 32'h4010);
    expRedir("R10 mret in user", 2'b11, 32'h100);
    csrR("R10 cause", 12'h342, 32'd2);
    csrR("R10 epc", 12'h341, 32'h4010);
    csrR("R6 mpp user", 12'h300, 32'h0);
    csrW(12'h341, 32'h5000);
    issue(0, 0, 0, 1, 0, 0, 32'h40);
    issue(0, 0, 0, 0, 1, 0, 32'h5004);
    expRedir("R10 sret in user", 2'b11, 32'h100);
    csrR("R10 sret cause", 12'h342, 32'd2);

    curTag = "R5";
    csrW(12'h302, 32'h924);
    issue(1, 0, 0, 0, 0, 0, 32'h6000);
    expRedir("R5 machine ecall stays", 2'b11, 32'h100);
    csrR("R2 cause 11", 12'h342, 32'd11);
    issue(0, 0, 1, 0, 0, 5'd5, 32'h6010);
    expRedir("R5 delegated cause in machine", 2'b11, 32'h100);
    csrR("R5 cause", 12'h342, 32'd5);

    curTag = "R4";
    csrW(12'h300, 32'h800); csrW(12'h341, 32'h7000);
    issue(0, 0, 0, 1, 0, 0, 32'h60);
    issue(0, 0, 1, 0, 0, 5'd5, 32'h7008);
    expRedir("R4 delegated exception", 2'b01, 32'h200);
    csrR("R2 generic cause", 12'h142, 32'd5);
    csrR("R7 spp from supervisor", 12'h100, 32'h100);
    issue(0, 0, 0, 0, 1, 0, 32'h70);
    expRedir("R9 sret spp set", 2'b01, 32'h7008);
    issue(0, 0, 0, 0, 1, 0, 32'h74);
    expRedir("R9 sret spp clear", 2'b00, 32'h7008);
    issue(0, 0, 1, 0, 0, 5'd13, 32'h7100);
    expRedir("R4 undelegated exception", 2'b11, 32'h100);
    csrR("R4 cause 13", 12'h342, 32'd13);

    curTag = "R12";
    csrW(12'h300, 32'h0); csrW(12'h341, 32'h8000);
    issue(0, 0, 0, 1, 0, 0, 32'h80);
    issue(1, 0, 1, 1, 0, 5'd5, 32'h8004);
    expRedir("R12 ecall beats exception", 2'b01, 32'h200);
    csrR("R12 ecall cause", 12'h142, 32'd8);
    issue(1, 1, 0, 0, 0, 0, 32'h8100);
    csrR("R12 illegal beats ecall", 12'h142, 32'd2);
    csrReq = 1; csrAddr = 12'h100; mretReq = 1; instrPc = 32'h8200;
    #1 check("R12 mret beats access", 32'(csrAck), 32'd0);
    cyc();
    csrR("R12 mret illegal cause", 12'h142, 32'd2);
    csrReq = 1; csrAddr = 12'h142; sretReq = 1; instrPc = 32'h8300;
    #1 check("R12 sret beats access", 32'(csrAck), 32'd0);
    cyc();
    expRedir("R12 sret result", 2'b01, 32'h8200);
    cyc();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule